// File: doc/BRIEF.md
# Accumulator ALU with Extended Flag Byte

This is a purely combinational arithmetic and logic unit for the accumulator of an 8-bit processor core. Each cycle it takes four inputs:

- the accumulator value,
- a second operand,
- the current flag byte,
- a four-bit operation code.

From these it forms a result byte, an updated flag byte and a flag write mask. The mask marks the flag bits that the selected operation defines. The surrounding core uses the mask to keep the bits that the operation leaves alone. In the flag byte output those bits are already copied from the input.

The flag byte has eight bits. Besides the usual sign, zero, half-carry, parity/overflow, subtract and carry bits, it carries two spare bits, X and Y. These copy bits 3 and 5 of a chosen byte. The unit also keeps several uncommon flag rules:

- Compare takes X and Y from the operand.
- Complement-carry moves the old carry into half-carry.
- Decimal adjust corrects in the direction given by the subtract flag.

Top module: `acc_alu`

## Requirements
- R1: Codes 0 (add), 1 (add with carry), 2 (subtract) and 3 (subtract with borrow) return the low 8 bits of A plus or minus the operand, with the carry-in taken from the input C only for codes 1 and 3. C is the 9th result bit (the borrow for subtracts). H is the carry or borrow across bit 3/4. P/V is signed overflow. N is 0 for adds and 1 for subtracts.
- R2: Codes 4 (AND), 5 (XOR) and 6 (OR) return the bitwise result. They clear N and C and set P/V to 1 when the result has an even number of ones. H is 1 for AND and 0 for XOR and OR.
- R3: Code 7 (compare) sets S, Z, H, P/V, N and C exactly as code 2 would, returns A unchanged, and copies X and Y from bits 3 and 5 of the operand.
- R4: Code 8 (increment A) clears N and sets P/V only when the result is 0x80. It sets H when the low nibble of the result is zero, and leaves C untouched.
- R5: Code 9 (decrement A) sets N and sets P/V only when the result is 0x7F. It sets H when the low nibble of A before the decrement is zero, and leaves C untouched.
- R6: Code 10 (negate) returns 0 minus A. It sets P/V when A was 0x80, sets C when A was nonzero, sets N, and sets H on a borrow out of the low nibble.
- R7: Code 11 (decimal adjust) applies a correction of 0x06 when H is set or the low nibble of A exceeds 9. It applies a correction of 0x60 when C is set or A exceeds 0x99. Both corrections are subtracted when N is 1 and added otherwise. The new C is the old C OR (A > 0x99), the new H is bit 4 of (A XOR result), P/V is even parity, and N is unchanged.
- R8: Code 12 (complement) returns the inverse of A and sets H and N. Code 13 (set carry) sets C and clears H and N. Code 14 (complement carry) clears N, copies the old C into H and inverts C. Codes 13 and 14 return A unchanged. Codes 12 to 14 leave S, Z and P/V unchanged.
- R9: The flag byte layout is S=bit 7, Z=bit 6, Y=bit 5, H=bit 4, X=bit 3, P/V=bit 2, N=bit 1, C=bit 0. Except for the X/Y rule of code 7, X and Y copy bits 3 and 5 of the result whenever the operation defines them, and S and Z follow the result byte.
- R10: The flag write mask has a 1 in every flag bit that the operation defines. Every flag bit outside the mask equals the input flag bit. Code 15 passes A through with a zero mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| acc_in | input | 8 | Accumulator value |
| opnd_in | input | 8 | Second operand |
| flag_in | input | 8 | Current flag byte |
| op_code | input | 4 | Operation select, 0 to 15 |
| res_out | output | 8 | Result byte |
| flag_out | output | 8 | Updated flag byte |
| flag_we | output | 8 | Flag write mask |

## Verification
Some properties can be checked on every input combination the bench applies:

- flag bits outside the write mask never differ from the input flags;
- compare never alters the accumulator;
- the logic operations always clear N and C;
- increment raises overflow only on 0x80;
- the zero flag matches the result wherever it is written.

Other behaviours can only be shown by the bench's directed corners and its reference-model sweep. These are the exact carry, half-carry and overflow values, the two decimal-adjust directions, the operand-sourced X/Y bits of compare, and the carry-to-half-carry move of complement-carry.

// File: rtl/acc_alu.sv
module acc_alu (
  input  logic [7:0] acc_in,
  input  logic [7:0] opnd_in,
  input  logic [7:0] flag_in,
  input  logic [3:0] op_code,
  output logic [7:0] res_out,
  output logic [7:0] flag_out,
  output logic [7:0] flag_we
);
  localparam int FS = 7, FZ = 6, FY = 5, FH = 4, FX = 3, FV = 2, FN = 1, FC = 0;
  localparam logic [3:0] OP_ADD = 4'd0, OP_ADC = 4'd1, OP_SUB = 4'd2, OP_SBC = 4'd3,
                         OP_AND = 4'd4, OP_XOR = 4'd5, OP_OR  = 4'd6, OP_CP  = 4'd7,
                         OP_INC = 4'd8, OP_DEC = 4'd9, OP_NEG = 4'd10, OP_DAA = 4'd11,
                         OP_CPL = 4'd12, OP_SCF = 4'd13, OP_CCF = 4'd14;

  logic       cy;
  logic       is_sub;
  logic       cin;
  logic [8:0] sum9;
  logic [7:0] hx;
  logic       ov_add, ov_sub;
  logic [7:0] neg_r;
  logic       lo_fix, hi_fix;
  logic [7:0] daa_adj, daa_r;

  assign cy     = flag_in[FC];
  assign is_sub = (op_code == OP_SUB) || (op_code == OP_SBC) || (op_code == OP_CP);
  assign cin    = ((op_code == OP_ADC) || (op_code == OP_SBC)) && cy;
  assign sum9   = is_sub ? ({1'b0, acc_in} - {1'b0, opnd_in} - {8'd0, cin})
                         : ({1'b0, acc_in} + {1'b0, opnd_in} + {8'd0, cin});
  assign hx     = acc_in ^ opnd_in ^ sum9[7:0];
  assign ov_add = (acc_in[7] == opnd_in[7]) && (sum9[7] != acc_in[7]);
  assign ov_sub = (acc_in[7] != opnd_in[7]) && (sum9[7] != acc_in[7]);
  assign neg_r  = 8'd0 - acc_in;

  assign lo_fix  = flag_in[FH] || (acc_in[3:0] > 4'd9);
  assign hi_fix  = cy || (acc_in > 8'h99);
  assign daa_adj = {1'b0, hi_fix, hi_fix, 1'b0, 1'b0, lo_fix, lo_fix, 1'b0};
  assign daa_r   = flag_in[FN] ? (acc_in - daa_adj) : (acc_in + daa_adj);

  logic [7:0] r, f, we;
  logic       szxy, xy_only;

  always_comb begin
    r = acc_in;
    f = flag_in;
    we = 8'h00;
    szxy = 1'b0;
    xy_only = 1'b0;
    case (op_code)
      OP_ADD, OP_ADC: begin
        r = sum9[7:0];
        f[FH] = hx[4]; f[FV] = ov_add; f[FN] = 1'b0; f[FC] = sum9[8];
        we = 8'hFF; szxy = 1'b1;
      end
      OP_SUB, OP_SBC: begin
        r = sum9[7:0];
        f[FH] = hx[4]; f[FV] = ov_sub; f[FN] = 1'b1; f[FC] = sum9[8];
        we = 8'hFF; szxy = 1'b1;
      end
      OP_CP: begin
        f[FS] = sum9[7]; f[FZ] = (sum9[7:0] == 8'd0);
        f[FY] = opnd_in[5]; f[FX] = opnd_in[3];
        f[FH] = hx[4]; f[FV] = ov_sub; f[FN] = 1'b1; f[FC] = sum9[8];
        we = 8'hFF;
      end
      OP_AND, OP_XOR, OP_OR: begin
        r = (op_code == OP_AND) ? (acc_in & opnd_in)
          : (op_code == OP_XOR) ? (acc_in ^ opnd_in) : (acc_in | opnd_in);
        f[FH] = (op_code == OP_AND); f[FN] = 1'b0; f[FC] = 1'b0; f[FV] = ~^r;
        we = 8'hFF; szxy = 1'b1;
      end
      OP_INC: begin
        r = acc_in + 8'd1;
        f[FN] = 1'b0; f[FV] = (r == 8'h80); f[FH] = (r[3:0] == 4'd0);
        we = 8'hFE; szxy = 1'b1;
      end
      OP_DEC: begin
        r = acc_in - 8'd1;
        f[FN] = 1'b1; f[FV] = (r == 8'h7F); f[FH] = (acc_in[3:0] == 4'd0);
        we = 8'hFE; szxy = 1'b1;
      end
      OP_NEG: begin
        r = neg_r;
        f[FV] = (acc_in == 8'h80); f[FC] = (acc_in != 8'd0); f[FN] = 1'b1;
        f[FH] = acc_in[4] ^ neg_r[4];
        we = 8'hFF; szxy = 1'b1;
      end
      OP_DAA: begin
        r = daa_r;
        f[FC] = hi_fix && (cy || (acc_in > 8'h99));
        f[FH] = acc_in[4] ^ daa_r[4]; f[FV] = ~^daa_r;
        we = 8'hFD; szxy = 1'b1;
      end
      OP_CPL: begin
        r = ~acc_in;
        f[FH] = 1'b1; f[FN] = 1'b1;
        we = 8'h3A; xy_only = 1'b1;
      end
      OP_SCF: begin
        f[FC] = 1'b1; f[FH] = 1'b0; f[FN] = 1'b0;
        we = 8'h3B; xy_only = 1'b1;
      end
      OP_CCF: begin
        f[FH] = cy; f[FC] = ~cy; f[FN] = 1'b0;
        we = 8'h3B; xy_only = 1'b1;
      end
      default: ;
    endcase
    if (szxy) begin
      f[FS] = r[7];
      f[FZ] = (r == 8'd0);
    end
    if (szxy || xy_only) begin
      f[FY] = r[5];
      f[FX] = r[3];
    end
  end

  assign res_out  = r;
  assign flag_out = f;
  assign flag_we  = we;
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk (
  input logic [7:0] acc_in,
  input logic [7:0] opnd_in,
  input logic [7:0] flag_in,
  input logic [3:0] op_code,
  input logic [7:0] res_out,
  input logic [7:0] flag_out,
  input logic [7:0] flag_we
);
  always_comb begin
    if (!$isunknown({acc_in, opnd_in, flag_in, op_code, res_out, flag_out, flag_we})) begin
      p_unmasked_hold_r10: assert (((flag_out ^ flag_in) & ~flag_we) == 8'h00)
        else $error("flag outside mask changed");
      p_cp_keeps_a_r3: assert (op_code != 4'd7 || res_out == acc_in)
        else $error("compare altered A");
      p_logic_clears_nc_r2: assert (!(op_code inside {4'd4, 4'd5, 4'd6}) || flag_out[1:0] == 2'b00)
        else $error("logic op left N or C set");
      p_inc_ovf_only_80_r4: assert (!(op_code == 4'd8 && flag_out[2]) || res_out == 8'h80)
        else $error("increment overflow on wrong value");
      p_zero_tracks_result_r9: assert (!(flag_we[6] && op_code != 4'd7) || flag_out[6] == (res_out == 8'd0))
        else $error("zero flag disagrees with result");
    end
  end
endmodule

bind acc_alu acc_alu_chk chk_i (
  .acc_in(acc_in), .opnd_in(opnd_in), .flag_in(flag_in), .op_code(op_code),
  .res_out(res_out), .flag_out(flag_out), .flag_we(flag_we)
);

// File: tb/acc_alu_tb_top.sv
module acc_alu_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] acc_in, opnd_in, flag_in, res_out, flag_out, flag_we;
  logic [3:0] op_code;
  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_alu dut_i (
    .acc_in(acc_in), .opnd_in(opnd_in), .flag_in(flag_in), .op_code(op_code),
    .res_out(res_out), .flag_out(flag_out), .flag_we(flag_we)
  );

  function automatic int sgn(input int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  function automatic int even_par(input int v);
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += (v >> i) & 1;
    return (ones % 2 == 0) ? 1 : 0;
  endfunction

  function automatic string tag_of(input int op);
    case (op)
      0, 1, 2, 3: return "R1";
      4, 5, 6:    return "R2";
      7:          return "R3";
      8:          return "R4";
      9:          return "R5";
      10:         return "R6";
      11:         return "R7";
      12, 13, 14: return "R8";
      default:    return "R10";
    endcase
  endfunction

  task automatic model(input int a, input int b, input int fl, input int op,
                       output int r, output int fo, output int m);
    int c = fl & 1, h = (fl >> 4) & 1, n = (fl >> 1) & 1;
    int s = (fl >> 7) & 1, z = (fl >> 6) & 1, y = (fl >> 5) & 1, x = (fl >> 3) & 1, v = (fl >> 2) & 1;
    int t, ci, sr;
    r = a; m = 0;
    case (op)
      0, 1: begin
        ci = (op == 1) ? c : 0;
        t = a + b + ci; r = t & 255; c = (t > 255);
        h = ((a & 15) + (b & 15) + ci) > 15;
        sr = sgn(a) + sgn(b) + ci; v = (sr > 127 || sr < -128); n = 0; m = 255;
      end
      2, 3, 7: begin
        ci = (op == 3) ? c : 0;
        t = a - b - ci; r = t & 255; c = (t < 0);
        h = ((a & 15) - (b & 15) - ci) < 0;
        sr = sgn(a) - sgn(b) - ci; v = (sr > 127 || sr < -128); n = 1; m = 255;
      end
      4, 5, 6: begin
        r = (op == 4) ? (a & b) : (op == 5) ? (a ^ b) : (a | b);
        h = (op == 4); c = 0; n = 0; v = even_par(r); m = 255;
      end
      8: begin r = (a + 1) & 255; n = 0; v = (r == 128); h = ((a & 15) == 15); m = 254; end
      9: begin r = (a + 255) & 255; n = 1; v = (r == 127); h = ((a & 15) == 0); m = 254; end
      10: begin r = (256 - a) & 255; v = (a == 128); c = (a != 0); n = 1; h = ((a & 15) != 0); m = 255; end
      11: begin
        t = 0;
        if (h || (a & 15) > 9) t += 6;
        if (c || a > 153) t += 96;
        r = n ? ((a - t) & 255) : ((a + t) & 255);
        c = c | (a > 153); h = ((a ^ r) >> 4) & 1; v = even_par(r); m = 253;
      end
      12: begin r = 255 - a; h = 1; n = 1; m = 58; end
      13: begin c = 1; h = 0; n = 0; m = 59; end
      14: begin h = c; c = 1 - c; n = 0; m = 59; end
      default: ;
    endcase
    if (op <= 11 && op != 7) begin s = (r >> 7) & 1; z = (r == 0); end
    if (op == 7) begin s = (t >> 7) & 1; z = ((t & 255) == 0); end
    if (op <= 14 && op != 7) begin y = (r >> 5) & 1; x = (r >> 3) & 1; end
    if (op == 7) begin y = (b >> 5) & 1; x = (b >> 3) & 1; r = a; end
    fo = (s << 7) | (z << 6) | (y << 5) | (h << 4) | (x << 3) | (v << 2) | (n << 1) | c;
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  task automatic apply(input int a, input int b, input int fl, input int op);
    int er, ef, em;
    @(posedge clk);
    #1;
    acc_in = a[7:0]; opnd_in = b[7:0]; flag_in = fl[7:0]; op_code = op[3:0];
    model(a, b, fl, op, er, ef, em);
    @(negedge clk);
    check(tag_of(op), "result", int'(res_out), er);
    check(tag_of(op), "flags", int'(flag_out), ef);
    check("R10", "mask", int'(flag_we), em);
    check("R9", "S/Z/Y/X", int'(flag_out) & 8'hE8, ef & 8'hE8);
  endtask

  initial begin
    acc_in = 8'h5A; opnd_in = 8'h00; flag_in = 8'hA5; op_code = 4'd15;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10", "reset pass result", int'(res_out), 8'h5A);
    check("R10", "reset pass mask", int'(flag_we), 0);
    check("R10", "reset pass flags", int'(flag_out), 8'hA5);
    apply(8'h7F, 8'h01, 0, 0);
    apply(8'hFF, 8'h01, 0, 0);
    apply(8'h0F, 8'h00, 1, 1);
    apply(8'h00, 8'h01, 0, 2);
    apply(8'h80, 8'h01, 1, 3);
    apply(8'h05, 8'h28, 0, 7);
    apply(8'h28, 8'h28, 8'hFF, 7);
    apply(8'h0F, 8'hF0, 8'hFF, 4);
    apply(8'h3C, 8'h0F, 0, 5);
    apply(8'h00, 8'h00, 8'hFF, 6);
    apply(8'h7F, 0, 1, 8);
    apply(8'hFF, 0, 0, 8);
    apply(8'h80, 0, 1, 9);
    apply(8'h00, 0, 0, 9);
    apply(8'h80, 0, 0, 10);
    apply(8'h00, 0, 8'hFF, 10);
    apply(8'h9A, 0, 0, 11);
    apply(8'h0F, 0, 8'h12, 11);
    apply(8'hA0, 0, 8'h03, 11);
    apply(8'h55, 0, 0, 12);
    apply(8'h28, 0, 8'hD4, 13);
    apply(8'h00, 0, 8'h01, 14);
    apply(8'hFF, 0, 8'h10, 14);
    apply(8'h33, 8'h44, 8'h5A, 15);
    for (int i = 0; i < 4000; i++)
      apply(int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
            int'($urandom_range(0, 255)), i % 16);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule